// File: doc/BRIEF.md
# PCI Address Window Decoder

This block classifies 32-bit addresses for a host-to-PCI bridge. The upper 256 MiB of the host map (from 0xF0000000 upward) is cut into 32 slices of 8 MiB. Slice i starts at 0xF0000000 + i*0x800000, and its index sits in address bits 27:23. An outbound (host-originated) access is passed to PCI memory only when its slice is enabled, when the forwarding mode is switched on, and when the slice is neither the lowest nor the highest one. The address is passed through with no translation. An inbound (PCI bus-master) access is sorted by fixed ranges into system RAM, PCI memory, a CPU-local range, or no target.

Software sets up two 32-bit registers through a plain write/read port. The first is a window-enable mask with one bit per slice. The second is a control word whose bits 8:7 hold the forwarding mode. Addresses arrive on a valid/ready request stream with a direction flag, and each one produces one response beat one cycle after it is accepted. A response that is not taken stays stable. The request side is ready whenever the response register is empty or is being drained in the same cycle, so back-pressure passes straight through with no extra buffering.

Top module: `pci_window_decoder`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1, both configuration registers read as 0, and an outbound access to any slice yields target 00.
- R2: A write with cfg_wr_sel=0 loads the window-enable mask and a write with cfg_wr_sel=1 loads the control word. Each register reads back all 32 bits unchanged on cfg_rd_data when cfg_rd_sel selects it, with the same select encoding.
- R3: An outbound address below 0xF0000000 always yields target 00 (none).
- R4: An outbound address in slice i (address bits 27:23, with 1 <= i <= 30) yields target 01 (PCI) when mask bit i is 1 and the control bits 8:7 equal 01. Otherwise it yields target 00. In every case rsp_addr equals the request address.
- R5: Control bits 8:7 set to 00, 10 or 11 block forwarding in every slice, whatever the mask holds. Other control bits have no effect on the decode.
- R6: Slices 0 and 31 never yield target 01, even when their mask bits are set and the mode is 01.
- R7: An inbound address below 0xF0800000 yields target 10 (RAM).
- R8: An inbound address from 0xF0800000 to 0xFF7FFFFF yields target 01 (PCI).
- R9: An inbound address from 0xFFF00000 to 0xFFFFEFFF yields target 11 (CPU-local). Inbound addresses from 0xFF800000 to 0xFFEFFFFF and from 0xFFFFF000 upward yield target 00. Inbound decode does not depend on either register.
- R10: A request accepted at a clock edge appears on rsp_valid/rsp_target/rsp_addr/rsp_inbound right after that edge. req_ready equals (not rsp_valid) or rsp_ready. While rsp_valid is 1 and rsp_ready is 0, the response stays unchanged.
- R11: A request accepted at the same edge as a register write is decoded with the register value from before the write. The next accepted request sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 window mask, 1 control word |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 1 | Readback select: 0 window mask, 1 control word |
| cfg_rd_data | output | 32 | Selected register contents |
| req_valid | input | 1 | Request address present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_inbound | input | 1 | 1 inbound bus-master access, 0 outbound host access |
| req_addr | input | 32 | Address to classify |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_inbound | output | 1 | Direction flag of the request that produced the response |
| rsp_target | output | 2 | 00 none, 01 PCI, 10 RAM, 11 CPU-local |
| rsp_addr | output | 32 | Request address, unchanged |

## Verification
The case that is hardest to reach from the ports is a configuration write that lands on the same edge as the acceptance of a request to the slice being changed. Only this case shows whether the decode uses the old value or the new one. The bench drives the write strobe and the request in one cycle, then sends a second request to the same slice. Stalled responses are reached by holding rsp_ready low while a second request waits, so the bench can check that the response is held and req_ready stays low. Every slice is swept under every mode with several mask patterns at the first, middle and last byte of the slice.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_PCI  = 2'b01,
    TGT_RAM  = 2'b10,
    TGT_CPU  = 2'b11
  } tgt_e;
endpackage

// File: rtl/pwd_regs.sv
module pwd_regs
  import pwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] win_en_q,
  output logic [DATA_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_en_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      if (wr_sel) ctrl_q   <= wr_data;
      else        win_en_q <= wr_data;
    end
  end

  assign rd_data = rd_sel ? ctrl_q : win_en_q;

  AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (win_en_q == $past(wr_data))); // R2
  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (ctrl_q == $past(wr_data))); // R2
endmodule

// File: rtl/pwd_out_dec.sv
module pwd_out_dec
  import pwd_pkg::*;
#(
  parameter int         WIN_LOG2  = 5,
  parameter int         WIN_SHIFT = 23,
  parameter int         MODE_LSB  = 7,
  parameter logic [1:0] MODE_ON   = 2'b01
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [(1<<WIN_LOG2)-1:0]   win_en,
  input  logic [DATA_W-1:0]          ctrl,
  output logic                       fwd
);
  localparam int NUM_WIN = 1 << WIN_LOG2;
  localparam int HI_W    = ADDR_W - WIN_SHIFT - WIN_LOG2;

  logic [NUM_WIN-1:0]  eligible;
  logic [WIN_LOG2-1:0] idx;
  logic                in_region;
  logic                mode_on;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_elig
    if (i == 0 || i == NUM_WIN - 1) begin : g_fixed_off
      assign eligible[i] = 1'b0;
    end else begin : g_prog
      assign eligible[i] = win_en[i];
    end
  end

  assign idx       = addr[WIN_SHIFT +: WIN_LOG2];
  assign in_region = &addr[ADDR_W-1 -: HI_W];
  assign mode_on   = (ctrl[MODE_LSB +: 2] == MODE_ON);
  assign fwd       = in_region && mode_on && eligible[idx];
endmodule

// File: rtl/pwd_in_dec.sv
module pwd_in_dec
  import pwd_pkg::*;
#(
  parameter int                WIN_LOG2  = 5,
  parameter int                WIN_SHIFT = 23,
  parameter logic [ADDR_W-1:0] CPU_LO    = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] CPU_HI    = 32'hFFFF_EFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);
  localparam int                NUM_WIN     = 1 << WIN_LOG2;
  localparam int                HI_W        = ADDR_W - WIN_SHIFT - WIN_LOG2;
  localparam logic [ADDR_W-1:0] REGION_BASE = {{HI_W{1'b1}}, {(ADDR_W-HI_W){1'b0}}};
  localparam logic [ADDR_W-1:0] PCI_LO      = REGION_BASE + (ADDR_W'(1) << WIN_SHIFT);
  localparam logic [ADDR_W-1:0] PCI_END     = REGION_BASE + (ADDR_W'(NUM_WIN - 1) << WIN_SHIFT);

  always_comb begin
    if (addr < PCI_LO)                        tgt = TGT_RAM;
    else if (addr < PCI_END)                  tgt = TGT_PCI;
    else if (addr >= CPU_LO && addr <= CPU_HI) tgt = TGT_CPU;
    else                                      tgt = TGT_NONE;
  end
endmodule

// File: rtl/pwd_rsp_stage.sv
module pwd_rsp_stage
  import pwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_inb,
  input  tgt_e              in_tgt,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_inb,
  output tgt_e              out_tgt,
  output logic [ADDR_W-1:0] out_addr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_inb   <= 1'b0;
      out_tgt   <= TGT_NONE;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_inb  <= in_inb;
        out_tgt  <= in_tgt;
        out_addr <= in_addr;
      end
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tgt) &&
                                   $stable(out_addr) && $stable(out_inb))); // R10
  AST_RSP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid)); // R10
endmodule

// File: rtl/pci_window_decoder.sv
module pci_window_decoder
  import pwd_pkg::*;
#(
  parameter int                WIN_LOG2  = 5,
  parameter int                WIN_SHIFT = 23,
  parameter int                MODE_LSB  = 7,
  parameter logic [1:0]        MODE_ON   = 2'b01,
  parameter logic [ADDR_W-1:0] CPU_LO    = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] CPU_HI    = 32'hFFFF_EFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_sel,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic              cfg_rd_sel,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_inbound,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_inbound,
  output logic [1:0]        rsp_target,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int NUM_WIN = 1 << WIN_LOG2;

  logic [DATA_W-1:0] win_en_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              out_fwd;
  tgt_e              in_tgt;
  tgt_e              sel_tgt;
  tgt_e              rsp_tgt_e;
  logic              accept;

  pwd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_sel   (cfg_wr_sel),
    .wr_data  (cfg_wr_data),
    .rd_sel   (cfg_rd_sel),
    .rd_data  (cfg_rd_data),
    .win_en_q (win_en_q),
    .ctrl_q   (ctrl_q)
  );

  pwd_out_dec #(
    .WIN_LOG2 (WIN_LOG2),
    .WIN_SHIFT(WIN_SHIFT),
    .MODE_LSB (MODE_LSB),
    .MODE_ON  (MODE_ON)
  ) u_out_dec (
    .addr   (req_addr),
    .win_en (win_en_q[NUM_WIN-1:0]),
    .ctrl   (ctrl_q),
    .fwd    (out_fwd)
  );

  pwd_in_dec #(
    .WIN_LOG2 (WIN_LOG2),
    .WIN_SHIFT(WIN_SHIFT),
    .CPU_LO   (CPU_LO),
    .CPU_HI   (CPU_HI)
  ) u_in_dec (
    .addr (req_addr),
    .tgt  (in_tgt)
  );

  always_comb begin
    if (req_inbound) sel_tgt = in_tgt;
    else             sel_tgt = out_fwd ? TGT_PCI : TGT_NONE;
  end

  pwd_rsp_stage u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_inb    (req_inbound),
    .in_tgt    (sel_tgt),
    .in_addr   (req_addr),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_inb   (rsp_inbound),
    .out_tgt   (rsp_tgt_e),
    .out_addr  (rsp_addr)
  );

  assign rsp_target = rsp_tgt_e;
  assign accept     = req_valid && req_ready;

  AST_EDGE_SLICES_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tgt_e == TGT_PCI) |->
      (rsp_addr[WIN_SHIFT +: WIN_LOG2] != '0 &&
       rsp_addr[WIN_SHIFT +: WIN_LOG2] != '1)); // R6
  AST_ADDR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> (rsp_valid && rsp_addr == $past(req_addr))); // R4
  AST_MODE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && !rsp_inbound && rsp_tgt_e == TGT_PCI) |->
      ($past(ctrl_q[MODE_LSB +: 2]) == MODE_ON)); // R5
  AST_CPU_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_inbound && rsp_tgt_e == TGT_CPU) |->
      (rsp_addr >= CPU_LO && rsp_addr <= CPU_HI)); // R9
  AST_LOW_OUTBOUND_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_inbound && rsp_addr < 32'hF000_0000) |->
      (rsp_tgt_e == TGT_NONE)); // R3
endmodule

// File: tb/pci_window_decoder_bench.sv
`timescale 1ns/1ps
module pci_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_wr_sel = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic        cfg_rd_sel = 1'b0;
  logic [31:0] cfg_rd_data;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_inbound = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_inbound;
  logic [1:0]  rsp_target;
  logic [31:0] rsp_addr;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pci_window_decoder u_pci_window_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_inbound(req_inbound),
    .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_inbound(rsp_inbound),
    .rsp_target(rsp_target), .rsp_addr(rsp_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_out(input logic [31:0] a, input logic [31:0] en,
                                         input logic [31:0] ctl);
    int idx;
    if (a < 32'hF000_0000) return 2'b00;
    idx = int'((a - 32'hF000_0000) / 32'h0080_0000);
    if (idx == 0 || idx == 31) return 2'b00;
    if (((ctl >> 7) & 32'h3) != 32'h1) return 2'b00;
    return en[idx] ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [1:0] exp_in(input logic [31:0] a);
    if (a < 32'hF080_0000) return 2'b10;
    if (a < 32'hFF80_0000) return 2'b01;
    if (a >= 32'hFFF0_0000 && a <= 32'hFFFF_EFFF) return 2'b11;
    return 2'b00;
  endfunction

  task automatic write_reg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic read_chk(input bit sel, input logic [31:0] exp, input string req);
    cfg_rd_sel = sel;
    #1;
    check(cfg_rd_data === exp, req, {32'b0, cfg_rd_data}, {32'b0, exp});
  endtask

  task automatic do_req(input bit inb, input logic [31:0] a, input logic [1:0] exp,
                        input string req);
    @(negedge clk);
    req_valid = 1'b1; req_inbound = inb; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_target === exp && rsp_addr === a && rsp_inbound === inb,
          req, {rsp_valid, rsp_inbound, rsp_target, 28'b0, rsp_addr},
          {1'b1, inb, exp, 28'b0, a});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] ctl;
    logic [31:0] base;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hAAAA_AAAA;
    pats[2] = 32'h5555_5555; pats[3] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid === 1'b0, "R1 rsp_valid", {63'b0, rsp_valid}, 64'd0);
    check(req_ready === 1'b1, "R1 req_ready", {63'b0, req_ready}, 64'd1);
    read_chk(1'b0, 32'h0, "R1 mask reset");
    read_chk(1'b1, 32'h0, "R1 ctrl reset");
    do_req(1'b0, 32'hF100_0000, 2'b00, "R1 no forwarding after reset");

    // R2 readback
    write_reg(1'b0, 32'hDEAD_BEEF);
    read_chk(1'b0, 32'hDEAD_BEEF, "R2 mask readback");
    write_reg(1'b1, 32'h1234_5678);
    read_chk(1'b1, 32'h1234_5678, "R2 ctrl readback");
    read_chk(1'b0, 32'hDEAD_BEEF, "R2 mask kept");

    // R3 below region
    write_reg(1'b0, 32'hFFFF_FFFF);
    write_reg(1'b1, 32'h0000_0080);
    do_req(1'b0, 32'h0000_0000, 2'b00, "R3 low zero");
    do_req(1'b0, 32'h8000_0000, 2'b00, "R3 mid");
    do_req(1'b0, 32'hEFFF_FFFF, 2'b00, "R3 just below");

    // R4 R5 R6 sweep: mask patterns x modes x slices x offsets
    for (int p = 0; p < 4; p++) begin
      write_reg(1'b0, pats[p]);
      for (int m = 0; m < 4; m++) begin
        ctl = (32'hA5C3_3E7F & ~32'h0000_0180) | (32'(m) << 7);
        write_reg(1'b1, ctl);
        read_chk(1'b1, ctl, "R2 ctrl sweep readback");
        for (int w = 0; w < 32; w++) begin
          base = 32'hF000_0000 + 32'(w) * 32'h0080_0000;
          do_req(1'b0, base, exp_out(base, pats[p], ctl),
                 (w == 0 || w == 31) ? "R6 edge slice start" : "R4 R5 slice start");
          do_req(1'b0, base + 32'h0040_1234, exp_out(base + 32'h0040_1234, pats[p], ctl),
                 "R4 R5 slice middle");
          do_req(1'b0, base + 32'h007F_FFFF, exp_out(base + 32'h007F_FFFF, pats[p], ctl),
                 (w == 0 || w == 31) ? "R6 edge slice end" : "R4 R5 slice end");
        end
      end
    end

    // R7 R8 R9 inbound sweep, with registers in a blocking state (no effect on inbound)
    write_reg(1'b0, 32'h0);
    write_reg(1'b1, 32'h0);
    for (int k = 0; k < 64; k++) begin
      base = 32'(k) * 32'h0400_0000;
      do_req(1'b1, base, exp_in(base), "R7 R8 R9 coarse inbound");
    end
    for (int w = 0; w < 32; w++) begin
      base = 32'hF000_0000 + 32'(w) * 32'h0080_0000;
      do_req(1'b1, base, exp_in(base), "R7 R8 slice start inbound");
      do_req(1'b1, base + 32'h007F_FFFF, exp_in(base + 32'h007F_FFFF), "R8 R9 slice end inbound");
    end
    do_req(1'b1, 32'hF07F_FFFF, 2'b10, "R7 last RAM byte");
    do_req(1'b1, 32'hF080_0000, 2'b01, "R8 first PCI byte");
    do_req(1'b1, 32'hFF7F_FFFF, 2'b01, "R8 last PCI byte");
    do_req(1'b1, 32'hFF80_0000, 2'b00, "R9 gap start");
    do_req(1'b1, 32'hFFEF_FFFF, 2'b00, "R9 gap end");
    do_req(1'b1, 32'hFFF0_0000, 2'b11, "R9 CPU first");
    do_req(1'b1, 32'hFFFF_EFFF, 2'b11, "R9 CPU last");
    do_req(1'b1, 32'hFFFF_F000, 2'b00, "R9 above CPU");
    do_req(1'b1, 32'hFFFF_FFFF, 2'b00, "R9 top");

    // R11 write and accept on the same edge
    write_reg(1'b1, 32'h0000_0080);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = 32'h0000_0020;
    req_valid = 1'b1; req_inbound = 1'b0; req_addr = 32'hF280_0010;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_target === 2'b00, "R11 same-edge uses old mask",
          {62'b0, rsp_target}, 64'd0);
    do_req(1'b0, 32'hF280_0010, 2'b01, "R11 next access uses new mask");

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_inbound = 1'b1; req_addr = 32'h0000_1000;
    @(negedge clk);
    req_addr = 32'hFFF0_0010;
    for (int c = 0; c < 3; c++) begin
      #1;
      check(req_ready === 1'b0, "R10 ready low on stall", {63'b0, req_ready}, 64'd0);
      check(rsp_valid === 1'b1 && rsp_target === 2'b10 && rsp_addr === 32'h0000_1000,
            "R10 held response", {30'b0, rsp_target, rsp_addr}, {30'b0, 2'b10, 32'h0000_1000});
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    #1;
    check(req_ready === 1'b1, "R10 ready follows rsp_ready", {63'b0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_target === 2'b11 && rsp_addr === 32'hFFF0_0010,
          "R10 second beat after drain", {30'b0, rsp_target, rsp_addr},
          {30'b0, 2'b11, 32'hFFF0_0010});
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 empty after drain", {63'b0, rsp_valid}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule